// File: doc/BRIEF.md
# Calendar clock with alarm and update window

This block keeps wall-clock time and date for a real-time clock: seconds, minutes, hours, weekday, day of month, month and a two-digit year counted from a configurable base year. It advances the time by one second on each one-second tick, as long as the oscillator divider select reads the running code. Internally the time is held in binary fields. The seven time registers presented to the outside are encoded in either packed BCD or plain binary, and the hours in either 24-hour form or 12-hour form with a PM flag, as the mode inputs select.

Each accepted tick opens an update window. The window starts with the update-in-progress flag, which stays high for a fixed number of clock cycles. When the window closes, the visible registers take the new time, the alarm bytes are compared with the new encoded time, and one-cycle pulses tell the surrounding register file to set its update-ended, alarm and interrupt-request flags. Software can overwrite the time through a load request, which takes the raw register bytes in the current encoding.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, day 0x01, month 0x01 and year 0x00. `uip` and all three pulses are low.
- R2: A tick is accepted only when `div_sel` equals 3'b010. With any other code the tick is ignored: `uip` stays low, no pulse occurs and the registers keep their values.
- R3: With `bin_mode`=1 every register holds the plain binary value. With `bin_mode`=0 it holds packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R4: With `hour24`=1 the hours register holds 0 to 23. With `hour24`=0 bits 6:0 hold the hour modulo 12, so midnight and noon both read 0, and bit 7 is set for hours 12 to 23.
- R5: The weekday counts 1 to 7 and wraps from 7 to 1 at midnight. The month counts 1 to 12. The year wraps from 99 to 0 after December 31.
- R6: The month lengths are 31,28,31,30,31,30,31,31,30,31,30,31. February has 29 days when the full year (BASE_YEAR plus the year register) is divisible by 4 and either not divisible by 100 or divisible by 400.
- R7: When `set_mode` is low, an accepted tick sampled at an edge raises `uip` at that edge, and `uip` stays high for UIP_CYCLES cycles. The registers keep their old values during the window and show the new time in the cycle in which `uip` falls.
- R8: While `set_mode` is high, `uip` is held low and closing windows leave the registers unchanged. The internal time still advances and `update_pulse` still fires. Registers reflect all elapsed seconds after the next update with `set_mode` low.
- R9: An alarm byte whose bits 7:6 are both 1 matches any value. A byte with only one of those bits set is compared exactly.
- R10: With `alarm_en` high, a match of all three alarm bytes against the new encoded seconds, minutes and hours produces `alarm_pulse` and `irq_pulse` in the same cycle as `update_pulse`.
- R11: Every closing window produces a one-cycle `update_pulse`. When `upd_irq_en` is high, `irq_pulse` is produced with it.
- R12: A `load_req` stores the seven raw bytes in the registers at the next edge. It sets the internal time to their decoded value under the current modes, and it takes precedence over a tick in the same cycle, which is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| div_sel | input | 3 | Oscillator divider select; 3'b010 runs the clock |
| set_mode | input | 1 | Halts register refresh and the update flag |
| bin_mode | input | 1 | 1 = binary registers, 0 = packed BCD |
| hour24 | input | 1 | 1 = 24-hour form, 0 = 12-hour form with PM bit 7 |
| alarm_en | input | 1 | Alarm interrupt enable |
| upd_irq_en | input | 1 | Update-ended interrupt enable |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hour | input | 8 | Alarm hours byte |
| load_req | input | 1 | Load the ld_* bytes as the new time |
| ld_sec | input | 8 | Seconds byte to load |
| ld_min | input | 8 | Minutes byte to load |
| ld_hour | input | 8 | Hours byte to load |
| ld_wday | input | 8 | Weekday byte to load |
| ld_mday | input | 8 | Day-of-month byte to load |
| ld_mon | input | 8 | Month byte to load |
| ld_year | input | 8 | Year byte to load |
| sec_o | output | 8 | Seconds register |
| min_o | output | 8 | Minutes register |
| hour_o | output | 8 | Hours register |
| wday_o | output | 8 | Weekday register |
| mday_o | output | 8 | Day-of-month register |
| mon_o | output | 8 | Month register |
| year_o | output | 8 | Year register |
| uip | output | 1 | Update in progress |
| alarm_pulse | output | 1 | Set alarm flag (one cycle) |
| update_pulse | output | 1 | Set update-ended flag (one cycle) |
| irq_pulse | output | 1 | Set interrupt-request flag and raise the interrupt (one cycle) |

## Verification
A wrong internal binary field stays hidden until the next window closes. It then appears in the encoded registers exactly UIP_CYCLES cycles after the tick, and a carry error shows only at the rollover boundary that exercises it. Each carry chain is therefore driven to its edge: seconds into minutes, 23:59:59 into the next day, the month ends, leap and non-leap February, and the year wrap. This is repeated in both encodings and both hour forms. A broken window counter or a broken alarm compare shows within one window as a misplaced `uip` fall or a missing or extra pulse.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int REG_W = 8;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hour;
        logic [2:0] wday;
        logic [4:0] mday;
        logic [3:0] mon;
        logic [6:0] year;
    } cal_time_t;

    typedef struct packed {
        logic [REG_W-1:0] sec;
        logic [REG_W-1:0] min;
        logic [REG_W-1:0] hour;
        logic [REG_W-1:0] wday;
        logic [REG_W-1:0] mday;
        logic [REG_W-1:0] mon;
        logic [REG_W-1:0] year;
    } cal_regs_t;

    localparam cal_time_t CAL_TIME_RST = '{sec: 6'd0, min: 6'd0, hour: 5'd0,
                                           wday: 3'd1, mday: 5'd1, mon: 4'd1,
                                           year: 7'd0};
    localparam cal_regs_t CAL_REGS_RST = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                           wday: 8'h01, mday: 8'h01, mon: 8'h01,
                                           year: 8'h00};

    // value 0..99 to register byte
    function automatic logic [7:0] enc8(input logic [6:0] v, input logic bin);
        int iv;
        iv = int'(v);
        return bin ? 8'(iv) : 8'(((iv / 10) << 4) | (iv % 10));
    endfunction

    // register byte to value
    function automatic logic [6:0] dec8(input logic [7:0] b, input logic bin);
        return bin ? 7'(b) : 7'(int'(b[7:4]) * 10 + int'(b[3:0]));
    endfunction

    function automatic logic leap_year(input int y);
        return ((y % 4) == 0) && (((y % 100) != 0) || ((y % 400) == 0));
    endfunction

    function automatic logic [4:0] month_days(input logic [3:0] mon, input int y);
        case (mon)
            4'd2:                      return leap_year(y) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/cal_step.sv
module cal_step
    import rtc_cal_pkg::*;
#(
    parameter int BASE_YEAR = 1980
) (
    input  cal_time_t cur,
    output cal_time_t nxt
);
    logic [4:0] dim;

    always_comb begin
        dim = month_days(cur.mon, BASE_YEAR + int'(cur.year));
        nxt = cur;
        if (cur.sec >= 6'd59) begin
            nxt.sec = 6'd0;
            if (cur.min >= 6'd59) begin
                nxt.min = 6'd0;
                if (cur.hour >= 5'd23) begin
                    nxt.hour = 5'd0;
                    nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
                    if (cur.mday >= dim) begin
                        nxt.mday = 5'd1;
                        if (cur.mon >= 4'd12) begin
                            nxt.mon  = 4'd1;
                            nxt.year = (cur.year >= 7'd99) ? 7'd0 : cur.year + 7'd1;
                        end else begin
                            nxt.mon = cur.mon + 4'd1;
                        end
                    end else begin
                        nxt.mday = cur.mday + 5'd1;
                    end
                end else begin
                    nxt.hour = cur.hour + 5'd1;
                end
            end else begin
                nxt.min = cur.min + 6'd1;
            end
        end else begin
            nxt.sec = cur.sec + 6'd1;
        end
    end
endmodule

// File: rtl/cal_codec.sv
module cal_codec
    import rtc_cal_pkg::*;
(
    input  logic      bin,
    input  logic      h24,
    input  cal_time_t t_in,
    input  cal_regs_t r_in,
    output cal_regs_t r_out,
    output cal_time_t t_out
);
    logic [4:0] h12;
    logic [7:0] hb;
    logic [6:0] hv;

    // encode direction
    always_comb begin
        h12 = (t_in.hour >= 5'd12) ? t_in.hour - 5'd12 : t_in.hour;
        r_out.sec  = enc8({1'b0, t_in.sec}, bin);
        r_out.min  = enc8({1'b0, t_in.min}, bin);
        hb = enc8({2'b0, h24 ? t_in.hour : h12}, bin);
        r_out.hour = h24 ? hb : {(t_in.hour >= 5'd12), hb[6:0]};
        r_out.wday = enc8({4'b0, t_in.wday}, bin);
        r_out.mday = enc8({2'b0, t_in.mday}, bin);
        r_out.mon  = enc8({3'b0, t_in.mon}, bin);
        r_out.year = enc8(t_in.year, bin);
    end

    // decode direction
    always_comb begin
        t_out.sec  = 6'(dec8(r_in.sec, bin));
        t_out.min  = 6'(dec8(r_in.min, bin));
        hv = h24 ? dec8(r_in.hour, bin) : dec8({1'b0, r_in.hour[6:0]}, bin);
        if (!h24 && r_in.hour[7]) hv = hv + 7'd12;
        t_out.hour = 5'(hv);
        t_out.wday = 3'(dec8(r_in.wday, bin));
        t_out.mday = 5'(dec8(r_in.mday, bin));
        t_out.mon  = 4'(dec8(r_in.mon, bin));
        t_out.year = dec8(r_in.year, bin);
    end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
    parameter int NF = 3,
    parameter int W  = 8
) (
    input  logic [NF-1:0][W-1:0] want,
    input  logic [NF-1:0][W-1:0] have,
    output logic                 hit
);
    logic [NF-1:0] fld_ok;

    for (genvar i = 0; i < NF; i++) begin : g_fld
        // both top bits set: field is a wildcard
        assign fld_ok[i] = (want[i][W-1:W-2] == 2'b11) || (want[i] == have[i]);
    end

    assign hit = &fld_ok;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int BASE_YEAR  = 1980,
    parameter int UIP_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic [2:0] div_sel,
    input  logic       set_mode,
    input  logic       bin_mode,
    input  logic       hour24,
    input  logic       alarm_en,
    input  logic       upd_irq_en,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    input  logic       load_req,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [7:0] ld_wday,
    input  logic [7:0] ld_mday,
    input  logic [7:0] ld_mon,
    input  logic [7:0] ld_year,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic       uip,
    output logic       alarm_pulse,
    output logic       update_pulse,
    output logic       irq_pulse
);
    localparam int         CNT_W    = (UIP_CYCLES > 1) ? $clog2(UIP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(UIP_CYCLES - 1);
    localparam logic [2:0] DIV_RUN  = 3'b010;

    cal_time_t        now_t, step_t, load_t;
    cal_regs_t        regs, enc_regs, ld_regs;
    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic             alm_hit;
    logic             tick_ok;

    assign ld_regs = '{sec: ld_sec, min: ld_min, hour: ld_hour, wday: ld_wday,
                       mday: ld_mday, mon: ld_mon, year: ld_year};
    assign tick_ok = sec_tick && (div_sel == DIV_RUN) && !busy;

    cal_step #(.BASE_YEAR(BASE_YEAR)) u_step (
        .cur (now_t),
        .nxt (step_t)
    );

    cal_codec u_codec (
        .bin   (bin_mode),
        .h24   (hour24),
        .t_in  (now_t),
        .r_in  (ld_regs),
        .r_out (enc_regs),
        .t_out (load_t)
    );

    alarm_cmp #(.NF(3), .W(REG_W)) u_alarm (
        .want ({alm_hour, alm_min, alm_sec}),
        .have ({enc_regs.hour, enc_regs.min, enc_regs.sec}),
        .hit  (alm_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            now_t        <= CAL_TIME_RST;
            regs         <= CAL_REGS_RST;
            busy         <= 1'b0;
            cnt          <= '0;
            uip          <= 1'b0;
            alarm_pulse  <= 1'b0;
            update_pulse <= 1'b0;
            irq_pulse    <= 1'b0;
        end else begin
            alarm_pulse  <= 1'b0;
            update_pulse <= 1'b0;
            irq_pulse    <= 1'b0;

            if (load_req) begin
                now_t <= load_t;
                regs  <= ld_regs;
            end else if (tick_ok) begin
                now_t <= step_t;
                busy  <= 1'b1;
                cnt   <= CNT_INIT;
                uip   <= !set_mode;
            end

            if (busy) begin
                if (cnt == '0) begin
                    busy         <= 1'b0;
                    uip          <= 1'b0;
                    update_pulse <= 1'b1;
                    alarm_pulse  <= alarm_en && alm_hit;
                    irq_pulse    <= (alarm_en && alm_hit) || upd_irq_en;
                    if (!set_mode && !load_req) regs <= enc_regs;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end

            if (set_mode) uip <= 1'b0;
        end
    end

    assign sec_o  = regs.sec;
    assign min_o  = regs.min;
    assign hour_o = regs.hour;
    assign wday_o = regs.wday;
    assign mday_o = regs.mday;
    assign mon_o  = regs.mon;
    assign year_o = regs.year;
endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       sec_tick,
    input logic [2:0] div_sel,
    input logic       set_mode,
    input logic       load_req,
    input logic [7:0] sec_o,
    input logic [7:0] hour_o,
    input logic [7:0] mday_o,
    input logic       uip,
    input logic       alarm_pulse,
    input logic       update_pulse,
    input logic       irq_pulse
);
    a_r2_frozen_no_uip: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && (div_sel != 3'b010) && !uip) |=> !uip);

    a_r8_set_holds_uip_low: assert property (@(posedge clk) disable iff (rst)
        set_mode |=> !uip);

    a_r7_uip_fall_ends_update: assert property (@(posedge clk) disable iff (rst)
        ($fell(uip) && !$past(set_mode)) |-> update_pulse);

    a_r11_update_one_cycle: assert property (@(posedge clk) disable iff (rst)
        update_pulse |=> !update_pulse);

    a_r11_irq_with_update: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> update_pulse);

    a_r10_alarm_with_irq: assert property (@(posedge clk) disable iff (rst)
        alarm_pulse |-> (update_pulse && irq_pulse));

    a_r12_sec_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(load_req) && !update_pulse) |-> $stable(sec_o));

    a_r12_hour_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(load_req) && !update_pulse) |-> $stable(hour_o));

    a_r12_mday_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(load_req) && !update_pulse) |-> $stable(mday_o));
endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (.*);

// File: tb/tb_rtc_calendar_core.sv
`timescale 1ns/1ps
module tb_rtc_calendar_core;
    localparam int UIPN = 8;
    localparam int NVEC = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic [2:0] div_sel = 3'b010;
    logic       set_mode = 1'b0, bin_mode = 1'b0, hour24 = 1'b1;
    logic       alarm_en = 1'b0, upd_irq_en = 1'b0;
    logic [7:0] alm_sec = 8'hC0, alm_min = 8'hC0, alm_hour = 8'hC0;
    logic       load_req = 1'b0;
    logic [7:0] ld_sec = 0, ld_min = 0, ld_hour = 0, ld_wday = 0, ld_mday = 0, ld_mon = 0, ld_year = 0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;
    logic       uip, alarm_pulse, update_pulse, irq_pulse;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    rtc_calendar_core #(.BASE_YEAR(1980), .UIP_CYCLES(UIPN)) dut (.*);

    always #2.5 clk = ~clk;

    // {bin, h24, load bytes sec..year, expected bytes sec..year}
    localparam logic [113:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00},
        {1'b0, 1'b1, 56'h59_59_23_03_28_02_20, 56'h00_00_00_04_29_02_20},
        {1'b0, 1'b1, 56'h59_59_23_03_28_02_21, 56'h00_00_00_04_01_03_21},
        {1'b0, 1'b1, 56'h59_59_23_05_29_02_24, 56'h00_00_00_06_01_03_24},
        {1'b1, 1'b1, 56'h38_22_0C_02_0F_06_05, 56'h39_22_0C_02_0F_06_05},
        {1'b1, 1'b1, 56'h3B_3B_17_04_1E_04_05, 56'h00_00_00_05_01_05_05},
        {1'b0, 1'b0, 56'h59_59_11_01_10_07_03, 56'h00_00_80_01_10_07_03},
        {1'b0, 1'b0, 56'h59_59_91_01_10_07_03, 56'h00_00_00_02_11_07_03},
        {1'b1, 1'b0, 56'h3B_05_81_03_0A_08_07, 56'h00_06_81_03_0A_08_07},
        {1'b0, 1'b1, 56'h59_59_09_02_15_03_10, 56'h00_00_10_02_15_03_10}
    };

    function automatic logic [55:0] regs_now();
        return {sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [55:0] b);
        @(negedge clk);
        {ld_sec, ld_min, ld_hour, ld_wday, ld_mday, ld_mon, ld_year} = b;
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
    endtask

    // tick, return uip seen after the tick edge and pulses at window end
    task automatic tick_wait(output logic uip_seen, output logic [2:0] pf);
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) sec_tick = 1'b0;
        uip_seen = uip;
        repeat (UIPN) @(negedge clk);
        pf = {alarm_pulse, update_pulse, irq_pulse};
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic       us;
        logic [2:0] pf;
        logic [55:0] hold;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset regs", 64'(regs_now()), 64'h00_00_00_01_01_01_00);
        chk("R1 reset flags", 64'({uip, alarm_pulse, update_pulse, irq_pulse}), 64'h0);

        // table walk: rollover, encodings, hour forms
        for (int i = 0; i < NVEC; i++) begin
            bin_mode = VEC[i][113];
            hour24   = VEC[i][112];
            do_load(VEC[i][111:56]);
            chk($sformatf("R12 load readback v%0d", i), 64'(regs_now()), 64'(VEC[i][111:56]));
            @(negedge clk) sec_tick = 1'b1;
            @(negedge clk) sec_tick = 1'b0;
            chk($sformatf("R7 uip raised v%0d", i), 64'(uip), 64'h1);
            repeat (UIPN - 1) @(negedge clk);
            chk($sformatf("R7 regs held in window v%0d", i), 64'({uip, regs_now()}),
                64'({1'b1, VEC[i][111:56]}));
            @(negedge clk);
            chk($sformatf("R3 R4 R5 R6 step v%0d", i), 64'({uip, update_pulse, regs_now()}),
                64'({1'b0, 1'b1, VEC[i][55:0]}));
        end

        // alarm and interrupt cases, BCD 24-hour, new time 10:20:30
        bin_mode = 1'b0;
        hour24   = 1'b1;
        alarm_en = 1'b1;
        alm_sec = 8'h30; alm_min = 8'h20; alm_hour = 8'h10;
        do_load(56'h29_20_10_01_01_01_00);
        tick_wait(us, pf);
        chk("R10 exact alarm match", 64'(pf), 64'b111);

        alm_sec = 8'h31;
        do_load(56'h29_20_10_01_01_01_00);
        tick_wait(us, pf);
        chk("R10 alarm mismatch", 64'(pf), 64'b010);

        alm_sec = 8'hC5;
        do_load(56'h29_20_10_01_01_01_00);
        tick_wait(us, pf);
        chk("R9 wildcard seconds", 64'(pf), 64'b111);

        alm_sec = 8'h80;
        do_load(56'h29_20_10_01_01_01_00);
        tick_wait(us, pf);
        chk("R9 single top bit is not wildcard", 64'(pf), 64'b010);

        alarm_en = 1'b0;
        alm_sec = 8'h30;
        upd_irq_en = 1'b1;
        do_load(56'h29_20_10_01_01_01_00);
        tick_wait(us, pf);
        chk("R11 update irq enabled", 64'(pf), 64'b011);
        upd_irq_en = 1'b0;
        tick_wait(us, pf);
        chk("R11 update irq disabled", 64'(pf), 64'b010);

        // set mode: no uip, no refresh, time keeps counting
        do_load(56'h29_20_10_01_01_01_00);
        set_mode = 1'b1;
        tick_wait(us, pf);
        chk("R8 uip low in set mode", 64'(us), 64'h0);
        chk("R8 update pulse in set mode", 64'(pf), 64'b010);
        chk("R8 regs frozen in set mode", 64'(regs_now()), 64'h29_20_10_01_01_01_00);
        set_mode = 1'b0;
        tick_wait(us, pf);
        chk("R8 regs catch up", 64'(regs_now()), 64'h31_20_10_01_01_01_00);

        // divider not running
        hold = regs_now();
        div_sel = 3'b110;
        tick_wait(us, pf);
        chk("R2 uip stays low when frozen", 64'(us), 64'h0);
        chk("R2 no pulses when frozen", 64'({pf, regs_now()}), 64'({3'b000, hold}));
        div_sel = 3'b010;

        // load wins over tick in the same cycle
        @(negedge clk);
        {ld_sec, ld_min, ld_hour, ld_wday, ld_mday, ld_mon, ld_year} = 56'h05_01_02_03_04_05_06;
        load_req = 1'b1;
        sec_tick = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        sec_tick = 1'b0;
        chk("R12 tick dropped on load", 64'(uip), 64'h0);
        repeat (UIPN + 1) @(negedge clk);
        chk("R12 loaded value kept", 64'({update_pulse, regs_now()}),
            64'({1'b0, 56'h05_01_02_03_04_05_06}));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule